// File: doc/BRIEF.md
# Input Line Event Detector

This block watches a bank of asynchronous input lines and turns selected activity on them into interrupt requests. Each line is brought into the system clock domain by a short flip-flop chain, and its synchronized value is compared with the value it had one clock earlier. A per-line configuration picks what counts as an event. The default is any change of the line. An alternate setting chooses an edge in one direction only, or a level that is held.

Detected events set sticky bits in a status vector. One mask vector selects which of those bits may raise the single interrupt output. Software reaches the block through a plain synchronous register port with a word address, a write strobe and a read strobe. Every configuration vector is changed through a pair of write-only addresses: one sets bits and one clears them. A separate address reads the vector back. Reading the status vector returns its contents and empties it in the same access. A line held at its selected level sets its bit again on every clock.

Top module: `evtdet_top`

## Requirements
- R1: After reset the mask, alternate-mode, detector-kind and polarity vectors read as zero, the status vector reads as zero and `irq` is low. With all mode bits at zero, every line detects any edge.
- R2: With its alternate-mode bit clear, a line sets its status bit on both rising and falling changes. If a pin change is applied before clock edge k, the status bit is set at edge k+2 and not before.
- R3: With alternate mode on and kind 0 (edge), a line with polarity 1 sets its bit only on rising changes. With polarity 0 it sets its bit only on falling changes.
- R4: With alternate mode on and kind 1 (level), a line sets its bit on every clock while its synchronized value equals its polarity bit (1 = high, 0 = low). This continues after status reads.
- R5: A read strobe at word address 12 returns the status vector on `regRdData` one cycle after the strobe. The same clock edge clears every status bit.
- R6: An event that is detected in the same cycle as a status read leaves its bit set after that read.
- R7: `irq` is high exactly when some line has both its status bit and its mask bit set.
- R8: The word addresses are: 0 mask set, 1 mask clear, 2 mask read; 3 alternate set, 4 alternate clear, 5 alternate read; 6 kind-to-edge (clears kind bits), 7 kind-to-level (sets kind bits), 8 kind read; 9 polarity falling/low (clears), 10 polarity rising/high (sets), 11 polarity read. A write changes only the bits written as 1.
- R9: A read at any address other than 2, 5, 8, 11 or 12 returns zero. A read at any address other than 12 leaves the status vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_LINES | Asynchronous input lines |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | NUM_LINES | Write data, one bit per line |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | NUM_LINES | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The lines are split across the five detector settings in a repeating pattern: any edge, rising, falling, high level and low level. The whole bank is then driven through all-zero, all-one, alternating and pseudo-random pin words. Each transition's expected status word is computed from the old and new pin values, so one sweep separates the edge directions from each other, separates edges from levels, and catches a level bit that is not re-armed after a read. Single-line tests count the clock edges from a pin change to `irq`. They also place a status read on exactly the cycle an event is detected, which separates "event wins" from "clear wins".

// File: rtl/evtdet_pkg.sv
package evtdet_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_MASK_ON   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASK_OFF  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK_RD   = 4'd2;
  localparam logic [ADDR_W-1:0] A_ALT_ON    = 4'd3;
  localparam logic [ADDR_W-1:0] A_ALT_OFF   = 4'd4;
  localparam logic [ADDR_W-1:0] A_ALT_RD    = 4'd5;
  localparam logic [ADDR_W-1:0] A_KIND_EDGE = 4'd6;
  localparam logic [ADDR_W-1:0] A_KIND_LVL  = 4'd7;
  localparam logic [ADDR_W-1:0] A_KIND_RD   = 4'd8;
  localparam logic [ADDR_W-1:0] A_POL_LOW   = 4'd9;
  localparam logic [ADDR_W-1:0] A_POL_HIGH  = 4'd10;
  localparam logic [ADDR_W-1:0] A_POL_RD    = 4'd11;
  localparam logic [ADDR_W-1:0] A_STATUS    = 4'd12;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic              maskSet;
    logic              maskClr;
    logic              altSet;
    logic              altClr;
    logic              kindEdge;
    logic              kindLevel;
    logic              polLow;
    logic              polHigh;
    logic              rdGo;
    logic              statusRd;
    logic [ADDR_W-1:0] rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/evtdet_ctrl.sv
module evtdet_ctrl
  import evtdet_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output ctlStrobe_t        ctl
);

  always_comb begin
    ctl           = '0;
    ctl.rdGo      = regRdEn;
    ctl.rdSel     = regAddr;
    ctl.statusRd  = regRdEn && (regAddr == A_STATUS);
    if (regWrEn) begin
      unique case (regAddr)
        A_MASK_ON:   ctl.maskSet   = 1'b1;
        A_MASK_OFF:  ctl.maskClr   = 1'b1;
        A_ALT_ON:    ctl.altSet    = 1'b1;
        A_ALT_OFF:   ctl.altClr    = 1'b1;
        A_KIND_EDGE: ctl.kindEdge  = 1'b1;
        A_KIND_LVL:  ctl.kindLevel = 1'b1;
        A_POL_LOW:   ctl.polLow    = 1'b1;
        A_POL_HIGH:  ctl.polHigh   = 1'b1;
        default:     ;
      endcase
    end
  end

  // R8: a single write touches at most one configuration vector
  assert_one_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.maskSet, ctl.maskClr, ctl.altSet, ctl.altClr,
              ctl.kindEdge, ctl.kindLevel, ctl.polLow, ctl.polHigh}));

  // R9: status clearing only comes from a read strobe
  assert_clear_needs_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.statusRd |-> regRdEn);

endmodule

// File: rtl/evtdet_sync.sv
module evtdet_sync #(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] rawIn,
  output logic [NUM_LINES-1:0] syncOut
);

  logic [NUM_LINES-1:0] chain [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= rawIn;
      for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[SYNC_STAGES-1];

endmodule

// File: rtl/evtdet_line.sv
module evtdet_line (
  input  logic nowVal,
  input  logic oldVal,
  input  logic altMode,
  input  logic levelKind,
  input  logic polHigh,
  output logic hit
);

  logic anyEdge, dirEdge, lvlMatch;

  always_comb begin
    anyEdge  = nowVal ^ oldVal;
    dirEdge  = polHigh ? (nowVal & ~oldVal) : (~nowVal & oldVal);
    lvlMatch = (nowVal == polHigh);
    if (!altMode)       hit = anyEdge;
    else if (levelKind) hit = lvlMatch;
    else                hit = dirEdge;
  end

endmodule

// File: rtl/evtdet_datapath.sv
module evtdet_datapath
  import evtdet_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic [NUM_LINES-1:0] wrData,
  input  ctlStrobe_t           ctl,
  output logic [NUM_LINES-1:0] rdData,
  output logic                 irq
);

  localparam logic [NUM_LINES-1:0] ZERO = '0;

  logic [NUM_LINES-1:0] syncVal, prevVal, evtVec;
  logic [NUM_LINES-1:0] maskReg, altReg, kindReg, polReg, statusReg;
  logic [NUM_LINES-1:0] rdDataReg, rdMux;

  evtdet_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .rawIn(pinIn), .syncOut(syncVal)
  );

  always_ff @(posedge clk) begin
    if (!rstN) prevVal <= '0;
    else       prevVal <= syncVal;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    evtdet_line line_i (
      .nowVal(syncVal[g]), .oldVal(prevVal[g]), .altMode(altReg[g]),
      .levelKind(kindReg[g]), .polHigh(polReg[g]), .hit(evtVec[g])
    );
  end

  // set/clear configuration vectors
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      altReg  <= '0;
      kindReg <= '0;
      polReg  <= '0;
    end else begin
      if (ctl.maskSet)   maskReg <= maskReg | wrData;
      if (ctl.maskClr)   maskReg <= maskReg & ~wrData;
      if (ctl.altSet)    altReg  <= altReg | wrData;
      if (ctl.altClr)    altReg  <= altReg & ~wrData;
      if (ctl.kindLevel) kindReg <= kindReg | wrData;
      if (ctl.kindEdge)  kindReg <= kindReg & ~wrData;
      if (ctl.polHigh)   polReg  <= polReg | wrData;
      if (ctl.polLow)    polReg  <= polReg & ~wrData;
    end
  end

  // status: read clears, a same-cycle event wins
  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (ctl.statusRd ? ZERO : statusReg) | evtVec;
  end

  always_comb begin
    unique case (ctl.rdSel)
      A_MASK_RD: rdMux = maskReg;
      A_ALT_RD:  rdMux = altReg;
      A_KIND_RD: rdMux = kindReg;
      A_POL_RD:  rdMux = polReg;
      A_STATUS:  rdMux = statusReg;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdDataReg <= '0;
    else if (ctl.rdGo) rdDataReg <= rdMux;
  end

  assign rdData = rdDataReg;
  assign irq    = |(statusReg & maskReg);

  // R5: after a status read only the newly detected events remain
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.statusRd |=> statusReg == $past(evtVec));

  // R5: the returned word is the status before the clear
  assert_read_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.statusRd |=> rdData == $past(statusReg));

  // R6: a detected event always lands in the status vector
  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusReg & $past(evtVec)) == $past(evtVec));

  // R9: without a status read no status bit is lost
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.statusRd |=> (statusReg & $past(statusReg)) == $past(statusReg));

  // R2: a newly set bit always comes from a detected event
  assert_set_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusReg & ~$past(statusReg) & ~$past(evtVec)) == ZERO);

  // R7: no mask, no interrupt
  assert_no_mask_no_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == ZERO) |-> !irq);

  // R8: the mask moves only on its own writes
  assert_mask_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.maskSet || ctl.maskClr) |=> $stable(maskReg));

endmodule

// File: rtl/evtdet_top.sv
module evtdet_top
  import evtdet_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [NUM_LINES-1:0] regWrData,
  input  logic                 regRdEn,
  output logic [NUM_LINES-1:0] regRdData,
  output logic                 irq
);

  ctlStrobe_t ctl;

  evtdet_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .ctl(ctl)
  );

  evtdet_datapath #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrData(regWrData),
    .ctl(ctl), .rdData(regRdData), .irq(irq)
  );

  // R1: interrupt is quiet in the cycle right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !irq);

endmodule

// File: tb/evtdet_top_tb_top.sv
module evtdet_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  pinIn = '0;
  logic [3:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [N-1:0]  regWrData = '0;
  logic          regRdEn = 1'b0;
  logic [N-1:0]  regRdData;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evtdet_top #(.NUM_LINES(N), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .irq(irq)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  logic [N-1:0] modeAny, modeRise, modeFall, modeHigh, modeLow, maskPat;

  initial begin
    logic [N-1:0] v, oldP, newP, expS, lfsr;
    for (int i = 0; i < N; i++) begin
      modeAny[i]  = (i % 5 == 0);
      modeRise[i] = (i % 5 == 1);
      modeFall[i] = (i % 5 == 2);
      modeHigh[i] = (i % 5 == 3);
      modeLow[i]  = (i % 5 == 4);
    end
    maskPat = 32'h0F0F_3C3C;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, '0);
    rd(4'd2, v);  check("R1 mask", v, '0);
    rd(4'd5, v);  check("R1 alt", v, '0);
    rd(4'd8, v);  check("R1 kind", v, '0);
    rd(4'd11, v); check("R1 pol", v, '0);
    rd(4'd12, v); check("R1 status", v, '0);

    // R2 latency on line 0 in default any-edge mode
    wr(4'd0, 32'h1);
    @(negedge clk); pinIn[0] = 1'b1;
    @(negedge clk); check("R2 irq after edge k", {31'd0, irq}, '0);
    @(negedge clk); check("R2 irq after edge k+1", {31'd0, irq}, '0);
    @(negedge clk); check("R2 irq after edge k+2", {31'd0, irq}, 32'h1);
    rd(4'd12, v); check("R5 status returned", v, 32'h1);
    rd(4'd12, v); check("R5 status cleared", v, '0);

    // R6 falling change detected exactly in the read cycle
    @(negedge clk); pinIn[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); regAddr = 4'd12; regRdEn = 1'b1;
    @(negedge clk); regRdEn = 1'b0;
    check("R6 read before event", regRdData, '0);
    rd(4'd2, v); check("R9 mask read", v, 32'h1);
    rd(4'd0, v); check("R9 write-only reads zero", v, '0);
    rd(4'd15, v); check("R9 unmapped reads zero", v, '0);
    rd(4'd12, v); check("R6 event kept", v, 32'h1);

    // R8 set/clear touches only written ones
    wr(4'd0, 32'h0000_00F0);
    rd(4'd2, v); check("R8 mask set", v, 32'h0000_00F1);
    wr(4'd1, 32'h0000_003C);
    rd(4'd2, v); check("R8 mask clear", v, 32'h0000_00C1);
    wr(4'd1, '1);
    wr(4'd0, maskPat);
    rd(4'd2, v); check("R8 mask pattern", v, maskPat);

    // configure five detector kinds
    wr(4'd3, ~modeAny);
    wr(4'd7, '1);
    wr(4'd6, ~(modeHigh | modeLow));
    wr(4'd10, modeRise | modeHigh);
    rd(4'd5, v);  check("R8 alt readback", v, ~modeAny);
    rd(4'd8, v);  check("R8 kind readback", v, modeHigh | modeLow);
    rd(4'd11, v); check("R8 pol readback", v, modeRise | modeHigh);
    wr(4'd4, 32'h0);
    rd(4'd5, v);  check("R8 zero write no effect", v, ~modeAny);
    rd(4'd12, v);

    // sweep of pin words, R2 R3 R4 R7
    lfsr = 32'hACE1_1234;
    for (int step = 0; step < 40; step++) begin
      oldP = pinIn;
      case (step)
        0: newP = '0;
        1: newP = '1;
        2: newP = '1;
        3: newP = '0;
        4: newP = 32'hA5A5_A5A5;
        5: newP = 32'h5A5A_5A5A;
        6: newP = 32'hFFFF_0000;
        7: newP = 32'h0000_FFFF;
        default: begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          newP = lfsr;
        end
      endcase
      @(negedge clk); pinIn = newP;
      repeat (5) @(negedge clk);
      expS = (modeAny & (oldP ^ newP))
           | (modeRise & ~oldP & newP)
           | (modeFall & oldP & ~newP)
           | (modeHigh & (oldP | newP))
           | (modeLow & (~oldP | ~newP));
      check("R7 irq", {31'd0, irq}, {31'd0, |(expS & maskPat)});
      rd(4'd12, v);
      check("R2 R3 R4 sweep status", v, expS);
    end

    // R4 held level re-sets after read
    rd(4'd12, v);
    check("R4 level re-armed", v & (modeHigh | modeLow),
          (modeHigh & pinIn) | (modeLow & ~pinIn));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule